// File: doc/BRIEF.md
# PWM Channel Counter with Edge and Center Alignment

This block is a single pulse-width-modulation channel. A counter measures the timebase. A comparator turns the counter value into the waveform on `pwm_out`. A small register bank holds the channel settings: a mode word, a duty value and a period value. The current count can be read back but not written. The counter advances only on strobes from one of two shared prescaled clock enables, `tick_a` and `tick_b`. The mode word picks which of the two strobes is used.

In edge-aligned operation the counter runs upward and wraps. In center-aligned operation it climbs to the period value and then descends to zero, so one waveform period takes twice as many strobes for the same period value. Each time a waveform period completes, the channel raises `period_end` for one cycle, which an interrupt collector can use as a per-period event.

Clock prescaling and the global enable sit outside the block. The enable arrives on `chan_en`. While it is low the counter freezes. A rising edge on it restarts the counter from zero.

Top module: `pwm_channel`

## Requirements
- R1: After reset the mode, duty, period and counter all read 0, `pwm_out` is 0 and `period_end` is 0.
- R2: A write with `reg_addr` 0 sets mode bits [2:0], and reads of address 0 return them with all higher bits 0. Address 1 holds the duty value and address 2 the period value, both read zero-extended. Address 3 reads the counter, and writes to address 3 leave the counter unchanged.
- R3: The counter steps only on a cycle where `chan_en` is high and the selected strobe is high. Mode bit 0 = 0 selects `tick_a`, and 1 selects `tick_b`.
- R4: With mode bit 1 = 0 (edge-aligned), each step takes the counter from value c to c+1. When c+1 is at or above the period value, the step goes to 0 instead. A period value of 0 or 1 therefore keeps the counter at 0.
- R5: With mode bit 1 = 1 (center-aligned), the counter steps up by 1 until it reaches the period value, then steps down by 1 until it reaches 0, then climbs again. One waveform period is 2×period steps, and a period value of 0 keeps the counter at 0.
- R6: `period_end` is high for exactly the one clock cycle after each step that completes a period. In edge-aligned mode this is the wrap to 0. In center-aligned mode it is a downward step that lands on 0, or a step taken while the counter is already at 0 with a period value of 0. It is never high after a cycle without a step.
- R7: While `chan_en` is low the counter holds its value and `period_end` stays 0, whatever the strobes do.
- R8: On the first clock edge at which `chan_en` is high after being low, the counter becomes 0 and the count direction becomes upward, without a step and without `period_end`.
- R9: The raw level is high when the duty value is nonzero and either the duty is at or above the period value or the counter is below the duty value. `pwm_out` is the raw level XOR mode bit 2, so bit 2 = 1 inverts the output.
- R10: The counter, duty and period are `CNT_W` bits wide, with `CNT_W` a parameter from 16 to `DATA_W`. Duty and period writes keep only the low `CNT_W` bits of `reg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel run enable from the global control |
| tick_a | input | 1 | First shared prescaled strobe |
| tick_b | input | 1 | Second shared prescaled strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 duty, 2 period, 3 counter |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM waveform |
| period_end | output | 1 | One-cycle end-of-period event |

## Verification
The bench builds the channel with `CNT_W` = 20 and `DATA_W` = 32. This gives a width that is neither the 16-bit minimum nor the bus width. Writes with bits set above bit 19 can then show the truncation and the zero-extended read-back at the ports. Center alignment stays built in, so both counting modes are exercised. The random phase uses period values from 0 to 12, which puts wraps, turn-arounds and the degenerate periods 0 and 1 within a few hundred cycles of each other.

// File: rtl/pwm_ch_pkg.sv
package pwm_ch_pkg;

   localparam int MODE_W = 3;

   // Mode word: bit 2 invert, bit 1 center-aligned, bit 0 strobe select
   typedef struct packed {
      logic invert;
      logic center;
      logic sel_b;
   } pwm_mode_t;

   typedef enum logic [1:0] {
      REG_MODE   = 2'd0,
      REG_DUTY   = 2'd1,
      REG_PERIOD = 2'd2,
      REG_COUNT  = 2'd3
   } pwm_reg_e;

endpackage

// File: rtl/pwm_ch_regs.sv
module pwm_ch_regs
   import pwm_ch_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   output pwm_mode_t         mode,
   output logic [CNT_W-1:0]  duty,
   output logic [CNT_W-1:0]  period,
   output logic [DATA_W-1:0] rdata
);

   localparam int PAD_W  = DATA_W - CNT_W;
   localparam int NUM_WIDE = 3;

   pwm_mode_t        mode_q;
   logic [CNT_W-1:0] duty_q;
   logic [CNT_W-1:0] period_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= '0;
         duty_q   <= '0;
         period_q <= '0;
      end else if (wr) begin
         unique case (pwm_reg_e'(addr))
            REG_MODE:   mode_q   <= pwm_mode_t'(wdata[MODE_W-1:0]);
            REG_DUTY:   duty_q   <= wdata[CNT_W-1:0];
            REG_PERIOD: period_q <= wdata[CNT_W-1:0];
            REG_COUNT:  ;
            default:    ;
         endcase
      end
   end

   // zero extension of the counter-width fields to the bus width
   logic [NUM_WIDE-1:0][CNT_W-1:0]  narrow;
   logic [NUM_WIDE-1:0][DATA_W-1:0] wide;

   assign narrow[0] = duty_q;
   assign narrow[1] = period_q;
   assign narrow[2] = cnt;

   for (genvar g = 0; g < NUM_WIDE; g++) begin : g_ext
      if (PAD_W > 0) begin : g_pad
         assign wide[g] = {{PAD_W{1'b0}}, narrow[g]};
      end else begin : g_flat
         assign wide[g] = narrow[g];
      end
   end

   if (PAD_W > 0) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:CNT_W];
   end

   always_comb begin
      unique case (pwm_reg_e'(addr))
         REG_MODE:   rdata = {{(DATA_W-MODE_W){1'b0}}, mode_q};
         REG_DUTY:   rdata = wide[0];
         REG_PERIOD: rdata = wide[1];
         REG_COUNT:  rdata = wide[2];
         default:    rdata = '0;
      endcase
   end

   assign mode   = mode_q;
   assign duty   = duty_q;
   assign period = period_q;

endmodule

// File: rtl/pwm_ch_counter.sv
module pwm_ch_counter #(
   parameter int CNT_W     = 16,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             center,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             period_end
);

   localparam logic [CNT_W:0]   ONE_X = (CNT_W+1)'(1);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   logic             en_q;
   logic             up_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pe_q;
   logic             center_eff;

   logic             nxt_up;
   logic [CNT_W-1:0] nxt_cnt;
   logic             nxt_pe;

   if (CENTER_EN) begin : g_center
      assign center_eff = center;
   end else begin : g_edge_only
      logic unused_center;
      assign unused_center = center;
      assign center_eff    = 1'b0;
   end

   always_comb begin
      nxt_cnt = cnt_q;
      nxt_up  = up_q;
      nxt_pe  = 1'b0;
      if (en && !en_q) begin
         nxt_cnt = '0;
         nxt_up  = 1'b1;
      end else if (en && tick) begin
         if (!center_eff) begin
            nxt_up = 1'b1;
            if (({1'b0, cnt_q} + ONE_X) >= {1'b0, period}) begin
               nxt_cnt = '0;
               nxt_pe  = 1'b1;
            end else begin
               nxt_cnt = cnt_q + ONE;
            end
         end else if (up_q && (cnt_q < period)) begin
            nxt_cnt = cnt_q + ONE;
         end else if (cnt_q <= ONE) begin
            nxt_cnt = '0;
            nxt_up  = 1'b1;
            nxt_pe  = 1'b1;
         end else begin
            nxt_cnt = cnt_q - ONE;
            nxt_up  = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         up_q  <= 1'b1;
         cnt_q <= '0;
         pe_q  <= 1'b0;
      end else begin
         en_q  <= en;
         up_q  <= nxt_up;
         cnt_q <= nxt_cnt;
         pe_q  <= nxt_pe;
      end
   end

   assign cnt        = cnt_q;
   assign period_end = pe_q;

endmodule

// File: rtl/pwm_ch_compare.sv
module pwm_ch_compare #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] duty,
   input  logic [CNT_W-1:0] period,
   input  logic             invert,
   output logic             pwm
);

   logic duty_zero;
   logic duty_full;
   logic raw;

   assign duty_zero = (duty == '0);
   assign duty_full = (duty >= period);
   assign raw       = !duty_zero && (duty_full || (cnt < duty));
   assign pwm       = raw ^ invert;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
   import pwm_ch_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 32,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              tick_a,
   input  logic              tick_b,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              pwm_out,
   output logic              period_end
);

   if (CNT_W < 16 || CNT_W > DATA_W) begin : g_bad_width
      $error("pwm_channel: CNT_W must lie between 16 and DATA_W");
   end
   if (DATA_W < MODE_W + 1) begin : g_bad_bus
      $error("pwm_channel: DATA_W too narrow for the mode word");
   end

   pwm_mode_t        mode_q;
   logic [CNT_W-1:0] duty_q;
   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sel_tick;

   pwm_ch_regs #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .cnt    (cnt_q),
      .mode   (mode_q),
      .duty   (duty_q),
      .period (period_q),
      .rdata  (reg_rdata)
   );

   assign sel_tick = mode_q.sel_b ? tick_b : tick_a;

   pwm_ch_counter #(
      .CNT_W     (CNT_W),
      .CENTER_EN (CENTER_EN)
   ) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (chan_en),
      .tick       (sel_tick),
      .center     (mode_q.center),
      .period     (period_q),
      .cnt        (cnt_q),
      .period_end (period_end)
   );

   pwm_ch_compare #(
      .CNT_W (CNT_W)
   ) u_compare (
      .cnt    (cnt_q),
      .duty   (duty_q),
      .period (period_q),
      .invert (mode_q.invert),
      .pwm    (pwm_out)
   );

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chan_en,
   input logic             tick_sel,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] duty,
   input logic [CNT_W-1:0] period,
   input logic [2:0]       mode_bits,
   input logic             pwm_out,
   input logic             period_end
);

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> $stable(cnt)); // R7

   AST_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && !tick_sel) |=> ($stable(cnt) || cnt == '0)); // R3

   AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_en) |=> (cnt == '0)); // R8

   AST_END_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |-> $past(chan_en && tick_sel)); // R6

   AST_OFF_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !period_end); // R7

   AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (duty == '0) |-> (pwm_out == mode_bits[2])); // R9

   AST_DUTY_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((duty != '0) && (duty >= period)) |-> (pwm_out != mode_bits[2])); // R9

endmodule

bind pwm_channel pwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chan_en    (chan_en),
   .tick_sel   (sel_tick),
   .cnt        (cnt_q),
   .duty       (duty_q),
   .period     (period_q),
   .mode_bits  (mode_q),
   .pwm_out    (pwm_out),
   .period_end (period_end)
);

// File: tb/pwm_channel_bench.sv
module pwm_channel_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CW         = 20;
   localparam int DW         = 32;
   localparam int unsigned MASK = (32'd1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chan_en = 1'b0;
   logic          tick_a = 1'b0;
   logic          tick_b = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          pwm_out;
   logic          period_end;

   int checks = 0;
   int errors = 0;

   // reference state
   int unsigned m_cnt = 0, m_duty = 0, m_prd = 0;
   logic [2:0]  m_mode = 3'd0;
   bit          m_up = 1'b1, m_enq = 1'b0, m_pe = 1'b0;
   logic [1:0]  m_addr = 2'd0;
   logic        cur_en = 1'b0;

   pwm_channel #(.CNT_W(CW), .DATA_W(DW), .CENTER_EN(1'b1)) u_pwm_channel (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_en    (chan_en),
      .tick_a     (tick_a),
      .tick_b     (tick_b),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .pwm_out    (pwm_out),
      .period_end (period_end)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic exp_pwm();
      logic r;
      if (m_duty == 0)          r = 1'b0;
      else if (m_duty >= m_prd) r = 1'b1;
      else                      r = (m_cnt < m_duty);
      return r ^ m_mode[2];
   endfunction

   function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0:    return {29'd0, m_mode};
         2'd1:    return DW'(m_duty);
         2'd2:    return DW'(m_prd);
         default: return DW'(m_cnt);
      endcase
   endfunction

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                        input string what, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one clock: check outputs, drive the next inputs, advance the reference
   task automatic step(input logic en, input logic ta, input logic tb,
                       input logic wr, input logic [1:0] a,
                       input logic [DW-1:0] wd, input string tag);
      logic sel;
      bit   pe;
      @(negedge clk);
      check(DW'(pwm_out), DW'(exp_pwm()), "pwm_out", tag);
      check(DW'(period_end), DW'(m_pe), "period_end", tag);
      check(reg_rdata, exp_read(m_addr), "reg_rdata", tag);
      chan_en = en; tick_a = ta; tick_b = tb;
      reg_wr = wr; reg_addr = a; reg_wdata = wd;
      sel = m_mode[0] ? tb : ta;
      pe  = 1'b0;
      if (en && !m_enq) begin
         m_cnt = 0; m_up = 1'b1;
      end else if (en && sel) begin
         if (!m_mode[1]) begin
            m_up = 1'b1;
            if (m_cnt + 1 >= m_prd) begin m_cnt = 0; pe = 1'b1; end
            else m_cnt = m_cnt + 1;
         end else if (m_up && m_cnt < m_prd) begin
            m_cnt = m_cnt + 1;
         end else if (m_cnt <= 1) begin
            m_cnt = 0; m_up = 1'b1; pe = 1'b1;
         end else begin
            m_cnt = m_cnt - 1; m_up = 1'b0;
         end
      end
      m_enq = en;
      m_pe  = pe;
      if (wr) begin
         case (a)
            2'd0: m_mode = wd[2:0];
            2'd1: m_duty = wd & MASK;
            2'd2: m_prd  = wd & MASK;
            default: ;
         endcase
      end
      m_addr = a;
      cur_en = en;
   endtask

   task automatic run(input int n, input logic en, input logic ta,
                      input logic tb, input string tag);
      for (int i = 0; i < n; i++) step(en, ta, tb, 1'b0, 2'd3, '0, tag);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] v, input string tag);
      step(cur_en, 1'b0, 1'b0, 1'b1, a, v, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd24680));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values on every register
      for (int a = 0; a < 4; a++) step(1'b0, 1'b0, 1'b0, 1'b0, 2'(a), '0, "R1");
      run(1, 1'b0, 1'b0, 1'b0, "R1");

      // R2 / R10: read-back, masking, counter is read-only
      wr_reg(2'd0, 32'hFFFF_FFF8, "R2");
      wr_reg(2'd0, 32'hFFFF_FFFF, "R2");
      wr_reg(2'd1, 32'hABCD_1234, "R10");
      wr_reg(2'd2, 32'h0FF5_5AA3, "R10");
      wr_reg(2'd3, 32'h0000_0055, "R2");
      run(2, 1'b0, 1'b1, 1'b1, "R2");
      wr_reg(2'd1, 32'h0000_0002, "R2");
      wr_reg(2'd0, 32'h0000_0000, "R2");
      wr_reg(2'd2, 32'h0000_0005, "R2");

      // R8 / R4: start, then edge-aligned wrap with period 5
      run(1, 1'b1, 1'b0, 1'b0, "R8");
      run(14, 1'b1, 1'b1, 1'b0, "R4");

      // R3: strobe selection
      run(5, 1'b1, 1'b0, 1'b1, "R3");
      wr_reg(2'd0, 32'h1, "R3");
      run(6, 1'b1, 1'b0, 1'b1, "R3");
      run(4, 1'b1, 1'b1, 1'b0, "R3");

      // R5: center-aligned, period 4
      wr_reg(2'd2, 32'd4, "R5");
      wr_reg(2'd0, 32'h3, "R5");
      run(20, 1'b1, 1'b0, 1'b1, "R5");

      // R7: disable holds counter, no events
      run(7, 1'b0, 1'b1, 1'b1, "R7");
      // R8: re-enable restarts from zero counting up
      run(1, 1'b1, 1'b0, 1'b1, "R8");
      run(9, 1'b1, 1'b0, 1'b1, "R8");

      // R6: degenerate periods give an event every step
      wr_reg(2'd2, 32'd0, "R6");
      run(4, 1'b1, 1'b0, 1'b1, "R6");
      wr_reg(2'd0, 32'h1, "R6");
      run(4, 1'b1, 1'b0, 1'b1, "R6");
      wr_reg(2'd2, 32'd1, "R4");
      run(4, 1'b1, 1'b0, 1'b1, "R4");

      // R9: duty zero, duty at period, inversion
      wr_reg(2'd2, 32'd6, "R9");
      wr_reg(2'd1, 32'd0, "R9");
      run(7, 1'b1, 1'b0, 1'b1, "R9");
      wr_reg(2'd1, 32'd6, "R9");
      run(7, 1'b1, 1'b0, 1'b1, "R9");
      wr_reg(2'd1, 32'd3, "R9");
      wr_reg(2'd0, 32'h5, "R9");
      run(8, 1'b1, 1'b0, 1'b1, "R9");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int unsigned r = $urandom_range(0, 99);
         logic en  = ($urandom_range(0, 99) < 95);
         logic ta  = 1'($urandom_range(0, 1));
         logic tb  = 1'($urandom_range(0, 1));
         if (r < 4) begin
            logic [1:0]    a = 2'($urandom_range(0, 3));
            logic [DW-1:0] v;
            case (a)
               2'd0:    v = DW'($urandom_range(0, 7));
               2'd1:    v = DW'($urandom_range(0, 14));
               2'd2:    v = DW'($urandom_range(0, 12));
               default: v = $urandom();
            endcase
            if ($urandom_range(0, 19) == 0) v = v | 32'hFFF0_0000;
            step(en, ta, tb, 1'b1, a, v, "R9");
         end else begin
            step(en, ta, tb, 1'b0, 2'($urandom_range(0, 3) == 0 ? 0 : 3), '0, "R6");
         end
      end
      run(2, 1'b1, 1'b0, 1'b0, "R6");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule